// File: doc/BRIEF.md
# Microcontroller Data Memory Space Router

This block takes one data-memory access per clock from an 8-bit microcontroller core and steers it to exactly one target. The targets are a 128-byte lower internal RAM, a 128-byte upper internal RAM, a special-function-register (SFR) port, an on-chip expanded RAM, or the external memory bus. Internal addresses at 80h and above are shared by two separate stores. An address-mode tag picks between them, not the address. Direct accesses reach the SFR port, and indirect accesses reach the upper RAM.

External-space (MOVX) accesses go to the on-chip expanded RAM when two things hold: the external-only bit is clear, and the address lies below the selected expanded-RAM size. Otherwise they go to the external bus. The expanded RAM therefore shadows the bottom of the 16-bit external space. A small control register holds the external-only bit and the size code.

All three RAMs sit inside the block. Read data from every target comes back one clock after the read strobe. The SFR port and the bus port are simple request/response ports. They must present read data in the cycle after their strobe.

Top module: `dmem_router`

## Requirements
- R1: With mode 00 (direct) or 01 (indirect), addresses 00h-7Fh select the lower RAM. Both modes reach the same storage, and neither strobes the SFR or bus port.
- R2: Mode 01 (indirect) at addresses 80h-FFh selects the upper RAM and never asserts `sfr_sel`. For example, an indirect write to A0h changes the upper-RAM byte and leaves the SFR at A0h unchanged.
- R3: Mode 00 (direct) at addresses 80h-FFh asserts `sfr_sel` with `sfr_addr` equal to the low address byte. `sfr_we` and `sfr_wdata` follow the write strobe and data. The upper RAM is not touched.
- R4: Mode 10 (MOVX) goes to the expanded RAM when the external-only bit is 0 and the 16-bit address is below the selected size. Such accesses do not strobe the bus.
- R5: The size code selects the expanded-RAM size: 00 = 256 bytes, 01 = 512, 10 = 1024, 11 = 1792. A MOVX address at or above the selected size goes to the external bus with `ext_addr` equal to the full address.
- R6: With the external-only bit set, every MOVX access goes to the external bus. Expanded-RAM contents are kept and become visible again once the bit is cleared.
- R7: `rd_data` carries the read result of the target chosen in the previous cycle. It is 00h when the previous cycle held no read.
- R8: At most one target is strobed per cycle. Mode 11, or no strobe, selects nothing. `sfr_we` and `ext_we` are asserted only with `wr_en`. When `rd_en` and `wr_en` are both set, the access is a write and returns no read data.
- R9: Synchronous active-low reset sets the external-only bit to 0 and the size code to 11. `cfg_wr` loads both fields, and the new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 16 | Access address (low byte for internal space) |
| acc_mode | input | 2 | 00 direct, 01 indirect, 10 MOVX, 11 none |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| cfg_wr | input | 1 | Load control register |
| cfg_ext_only_in | input | 1 | New external-only bit |
| cfg_size_in | input | 2 | New expanded-RAM size code |
| rd_data | output | 8 | Read data, one cycle after the read |
| sfr_sel | output | 1 | SFR port request |
| sfr_we | output | 1 | SFR port write |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid the cycle after request |
| ext_sel | output | 1 | External bus request |
| ext_we | output | 1 | External bus write |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External read data, valid the cycle after request |

## Verification
Port strobes, addresses and write data are combinational and appear in the same cycle as the access. The bench therefore checks them shortly after driving inputs on the falling edge. Read data arrives one rising edge later, so the expected byte for a read is held until the next falling edge and compared there, before new inputs are driven. A control-register load affects routing only from the access after the loading edge, and the reference model applies it at that point.

// File: rtl/dmem_router_pkg.sv
// Shared types for the data memory router: access mode codes, target
// identifiers and the expanded-RAM size decode.
package dmem_router_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_INDIRECT = 2'b01,
        MODE_MOVX     = 2'b10,
        MODE_NONE     = 2'b11
    } acc_mode_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_LO   = 3'd1,
        TGT_UP   = 3'd2,
        TGT_SFR  = 3'd3,
        TGT_XRAM = 3'd4,
        TGT_EXT  = 3'd5
    } tgt_e;

    // Byte count of the visible expanded RAM for a size code; code 11 gives the full array.
    function automatic logic [16:0] xram_limit(input logic [1:0] code, input int unsigned full);
        case (code)
            2'b00:   return 17'd256;
            2'b01:   return 17'd512;
            2'b10:   return 17'd1024;
            default: return full[16:0];
        endcase
    endfunction

endpackage

// File: rtl/dmem_cfg.sv
// Control register holding the external-only bit and the expanded-RAM size code.
// Assumes loads arrive as a single-cycle cfg_wr pulse; values act from the next cycle.
module dmem_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       ext_only_in,
    input  logic [1:0] size_in,
    output logic       ext_only_q,
    output logic [1:0] size_q
);

    // Reset to bus-shadowing enabled with the largest size; load on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_only_q <= 1'b0;
            size_q     <= 2'b11;
        end else if (cfg_wr) begin
            ext_only_q <= ext_only_in;
            size_q     <= size_in;
        end
    end

endmodule

// File: rtl/dmem_decode.sv
// Combinational target decode for one access.
// Assumes the mode tag is stable while either strobe is high; mode 11 is a no-op.
module dmem_decode
    import dmem_router_pkg::*;
#(
    parameter int unsigned XRAM_BYTES = 1792
) (
    input  logic [15:0] addr,
    input  logic [1:0]  mode,
    input  logic        rd,
    input  logic        wr,
    input  logic        ext_only,
    input  logic [1:0]  size,
    output tgt_e        tgt
);

    logic xram_hit;

    // Expanded RAM is visible only when enabled and the address is under the size.
    always_comb xram_hit = !ext_only && ({1'b0, addr} < xram_limit(size, XRAM_BYTES));

    // Pick one target from mode and address; high internal half splits by mode.
    always_comb begin
        tgt = TGT_NONE;
        if (rd || wr) begin
            case (acc_mode_e'(mode))
                MODE_DIRECT:   tgt = addr[7] ? TGT_SFR : TGT_LO;
                MODE_INDIRECT: tgt = addr[7] ? TGT_UP  : TGT_LO;
                MODE_MOVX:     tgt = xram_hit ? TGT_XRAM : TGT_EXT;
                default:       tgt = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dmem_sram.sv
// Single-port synchronous RAM: write on en&we, registered read on en&!we.
// Assumes the address is always inside DEPTH when enabled; contents undefined at reset.
module dmem_sram #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store on write, capture the addressed word on read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end

endmodule

// File: rtl/dmem_router.sv
// Data memory space router: steers each access to lower RAM, upper RAM, the SFR
// port, expanded RAM or the external bus, and returns read data one cycle later.
// Assumes SFR and bus ports supply read data in the cycle after their strobe.
module dmem_router
    import dmem_router_pkg::*;
#(
    parameter int unsigned XRAM_BYTES = 1792,
    parameter int unsigned IRAM_HALF  = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] acc_addr,
    input  logic [1:0]  acc_mode,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        cfg_wr,
    input  logic        cfg_ext_only_in,
    input  logic [1:0]  cfg_size_in,
    output logic [7:0]  rd_data,
    output logic        sfr_sel,
    output logic        sfr_we,
    output logic [7:0]  sfr_addr,
    output logic [7:0]  sfr_wdata,
    input  logic [7:0]  sfr_rdata,
    output logic        ext_sel,
    output logic        ext_we,
    output logic [15:0] ext_addr,
    output logic [7:0]  ext_wdata,
    input  logic [7:0]  ext_rdata
);

    localparam int unsigned XAW = $clog2(XRAM_BYTES);
    localparam int unsigned IAW = $clog2(IRAM_HALF);

    logic       ext_only_q;
    logic [1:0] size_q;
    tgt_e       tgt;
    tgt_e       ret_q;
    logic       lo_en, up_en, x_en;
    logic [7:0] lo_q, up_q, x_q;

    dmem_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .ext_only_in (cfg_ext_only_in),
        .size_in     (cfg_size_in),
        .ext_only_q  (ext_only_q),
        .size_q      (size_q)
    );

    dmem_decode #(.XRAM_BYTES(XRAM_BYTES)) u_dec (
        .addr     (acc_addr),
        .mode     (acc_mode),
        .rd       (rd_en),
        .wr       (wr_en),
        .ext_only (ext_only_q),
        .size     (size_q),
        .tgt      (tgt)
    );

    // Per-target strobes derived from the single decoded target.
    always_comb begin
        lo_en   = (tgt == TGT_LO);
        up_en   = (tgt == TGT_UP);
        x_en    = (tgt == TGT_XRAM);
        sfr_sel = (tgt == TGT_SFR);
        ext_sel = (tgt == TGT_EXT);
    end

    // Outgoing port fields; writes gated by the port select.
    always_comb begin
        sfr_we    = sfr_sel && wr_en;
        sfr_addr  = acc_addr[7:0];
        sfr_wdata = wr_data;
        ext_we    = ext_sel && wr_en;
        ext_addr  = acc_addr;
        ext_wdata = wr_data;
    end

    dmem_sram #(.DEPTH(IRAM_HALF)) u_lo (
        .clk   (clk),
        .en    (lo_en),
        .we    (wr_en),
        .addr  (acc_addr[IAW-1:0]),
        .wdata (wr_data),
        .rdata (lo_q)
    );

    dmem_sram #(.DEPTH(IRAM_HALF)) u_up (
        .clk   (clk),
        .en    (up_en),
        .we    (wr_en),
        .addr  (acc_addr[IAW-1:0]),
        .wdata (wr_data),
        .rdata (up_q)
    );

    dmem_sram #(.DEPTH(XRAM_BYTES)) u_xram (
        .clk   (clk),
        .en    (x_en),
        .we    (wr_en),
        .addr  (acc_addr[XAW-1:0]),
        .wdata (wr_data),
        .rdata (x_q)
    );

    // Remember which target a read went to, so the return mux picks it next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ret_q <= TGT_NONE;
        else        ret_q <= (rd_en && !wr_en) ? tgt : TGT_NONE;
    end

    // Return mux over RAM outputs and port responses.
    always_comb begin
        case (ret_q)
            TGT_LO:   rd_data = lo_q;
            TGT_UP:   rd_data = up_q;
            TGT_XRAM: rd_data = x_q;
            TGT_SFR:  rd_data = sfr_rdata;
            TGT_EXT:  rd_data = ext_rdata;
            default:  rd_data = 8'h00;
        endcase
    end

    assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lo_en, up_en, x_en, sfr_sel, ext_sel}));

    assert_port_write_needs_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (!sfr_we && !ext_we));

    assert_indirect_high_to_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && acc_mode == MODE_INDIRECT && acc_addr[7]) |-> (up_en && !sfr_sel));

    assert_direct_high_to_sfr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && acc_mode == MODE_DIRECT && acc_addr[7]) |-> (sfr_sel && !up_en));

    assert_xram_within_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        x_en |-> (!ext_only_q && ({1'b0, acc_addr} < xram_limit(size_q, XRAM_BYTES))));

    assert_ext_only_to_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && acc_mode == MODE_MOVX && ext_only_q) |-> ext_sel);

    assert_no_read_zero_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> (rd_data == 8'h00));

endmodule

// File: tb/dmem_router_test.sv
`timescale 1ns/1ps
module dmem_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_mode = 2'b11;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        cfg_wr = 1'b0, cfg_ext_only_in = 1'b0;
    logic [1:0]  cfg_size_in = 2'b11;
    logic [7:0]  rd_data;
    logic        sfr_sel, sfr_we, ext_sel, ext_we;
    logic [7:0]  sfr_addr, sfr_wdata, ext_wdata;
    logic [15:0] ext_addr;
    logic [7:0]  sfr_rdata = '0, ext_rdata = '0;

    always #2.5 clk = ~clk;

    dmem_router uut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_mode(acc_mode),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .cfg_wr(cfg_wr),
        .cfg_ext_only_in(cfg_ext_only_in), .cfg_size_in(cfg_size_in),
        .rd_data(rd_data), .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_sel(ext_sel),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    // Bench-side devices behind the SFR and bus ports.
    logic [7:0] dev_sfr [256];
    logic [7:0] dev_ext [int];

    function automatic logic [7:0] bus_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (sfr_sel) begin
            if (sfr_we) dev_sfr[sfr_addr] = sfr_wdata;
            else        sfr_rdata <= dev_sfr[sfr_addr];
        end
        if (ext_sel) begin
            if (ext_we) dev_ext[int'(ext_addr)] = ext_wdata;
            else        ext_rdata <= dev_ext.exists(int'(ext_addr)) ? dev_ext[int'(ext_addr)] : bus_pat(ext_addr);
        end
    end

    // Reference model state.
    logic [7:0] m_lo [128];
    logic [7:0] m_up [128];
    logic [7:0] m_x  [1792];
    logic [7:0] m_sfr [256];
    logic [7:0] m_ext [int];
    bit         m_ext_only = 1'b0;
    int         m_size = 3;
    logic [7:0] exp_rd = 8'h00;
    string      prev_tag = "R9";
    int         n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int lim(input int code);
        case (code)
            0: return 256;
            1: return 512;
            2: return 1024;
            default: return 1792;
        endcase
    endfunction

    // One access: check last read return, drive, check strobes, advance model.
    task automatic acc(input logic [15:0] a, input int m, input bit r, input bit w,
                       input logic [7:0] d, input string tag);
        int t;
        @(negedge clk);
        chk(rd_data === exp_rd, prev_tag, "rd_data", int'(rd_data), int'(exp_rd));
        cfg_wr = 1'b0; acc_addr = a; acc_mode = m[1:0]; rd_en = r; wr_en = w; wr_data = d;
        #1;
        // 0 none, 1 lo, 2 up, 3 sfr, 4 xram, 5 bus
        if (!(r || w) || m == 3)          t = 0;
        else if (m == 2)                  t = (!m_ext_only && int'(a) < lim(m_size)) ? 4 : 5;
        else if (a[7] == 1'b0)            t = 1;
        else                              t = (m == 0) ? 3 : 2;
        chk(sfr_sel === (t == 3), "R8", "sfr_sel", int'(sfr_sel), int'(t == 3));
        chk(sfr_we === (t == 3 && w), "R8", "sfr_we", int'(sfr_we), int'(t == 3 && w));
        chk(ext_sel === (t == 5), "R8", "ext_sel", int'(ext_sel), int'(t == 5));
        chk(ext_we === (t == 5 && w), "R8", "ext_we", int'(ext_we), int'(t == 5 && w));
        if (t == 3) chk(sfr_addr === a[7:0] && (!w || sfr_wdata === d), "R3", "sfr_addr", int'(sfr_addr), int'(a[7:0]));
        if (t == 5) chk(ext_addr === a && (!w || ext_wdata === d), "R5", "ext_addr", int'(ext_addr), int'(a));
        exp_rd = 8'h00;
        if (w) begin
            case (t)
                1: m_lo[a[6:0]] = d;
                2: m_up[a[6:0]] = d;
                3: m_sfr[a[7:0]] = d;
                4: m_x[a[10:0]] = d;
                5: m_ext[int'(a)] = d;
                default: ;
            endcase
        end else if (r) begin
            case (t)
                1: exp_rd = m_lo[a[6:0]];
                2: exp_rd = m_up[a[6:0]];
                3: exp_rd = m_sfr[a[7:0]];
                4: exp_rd = m_x[a[10:0]];
                5: exp_rd = m_ext.exists(int'(a)) ? m_ext[int'(a)] : bus_pat(a);
                default: ;
            endcase
        end
        prev_tag = tag;
    endtask

    // Load the control register; the model uses new values from the next access.
    task automatic set_cfg(input bit eo, input int sz);
        @(negedge clk);
        chk(rd_data === exp_rd, prev_tag, "rd_data", int'(rd_data), int'(exp_rd));
        rd_en = 1'b0; wr_en = 1'b0; acc_mode = 2'b11;
        cfg_wr = 1'b1; cfg_ext_only_in = eo; cfg_size_in = sz[1:0];
        exp_rd = 8'h00; prev_tag = "R9";
        m_ext_only = eo; m_size = sz;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin dev_sfr[i] = 8'h00; m_sfr[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state, then full 1792-byte window with expanded RAM enabled
        acc(16'h0000, 3, 0, 0, 8'h00, "R9");
        acc(16'h06FF, 2, 0, 1, 8'hE1, "R9");
        // Preload every internal and expanded RAM byte
        for (int i = 0; i < 128; i++) acc(16'(i), 0, 0, 1, 8'(i * 3 + 1), "R1");
        for (int i = 128; i < 256; i++) acc(16'(i), 1, 0, 1, 8'(i * 5 + 7), "R2");
        for (int i = 0; i < 1792; i++) acc(16'(i), 2, 0, 1, 8'(i ^ 8'hC3), "R4");
        acc(16'h06FF, 2, 1, 0, 8'h00, "R9");
        // R1: lower RAM shared by direct and indirect
        acc(16'h0010, 0, 0, 1, 8'h11, "R1");
        acc(16'h0010, 1, 1, 0, 8'h00, "R1");
        acc(16'h007F, 1, 0, 1, 8'h22, "R1");
        acc(16'h007F, 0, 1, 0, 8'h00, "R1");
        // R2/R3: same address A0h, separate stores
        acc(16'h00A0, 0, 0, 1, 8'hAA, "R3");
        acc(16'h00A0, 1, 0, 1, 8'h55, "R2");
        acc(16'h00A0, 0, 1, 0, 8'h00, "R2");
        acc(16'h00A0, 1, 1, 0, 8'h00, "R3");
        acc(16'h00FF, 1, 0, 1, 8'h99, "R2");
        acc(16'h00FF, 0, 1, 0, 8'h00, "R3");
        acc(16'h00FF, 1, 1, 0, 8'h00, "R2");
        // R4/R5: expanded RAM and its upper boundary
        acc(16'h0000, 2, 0, 1, 8'h01, "R4");
        acc(16'h0000, 2, 1, 0, 8'h00, "R4");
        acc(16'h0700, 2, 0, 1, 8'h77, "R5");
        acc(16'h0700, 2, 1, 0, 8'h00, "R5");
        acc(16'hFFFF, 2, 1, 0, 8'h00, "R5");
        for (int s = 0; s < 3; s++) begin
            set_cfg(1'b0, s);
            acc(16'(lim(s) - 1), 2, 1, 0, 8'h00, "R5");
            acc(16'(lim(s)), 2, 1, 0, 8'h00, "R5");
            acc(16'(lim(s)), 2, 0, 1, 8'h3C, "R5");
            acc(16'(lim(s)), 2, 1, 0, 8'h00, "R5");
        end
        // R6: external-only hides the expanded RAM, contents kept
        set_cfg(1'b1, 3);
        acc(16'h0000, 2, 1, 0, 8'h00, "R6");
        acc(16'h0000, 2, 0, 1, 8'h66, "R6");
        acc(16'h0000, 2, 1, 0, 8'h00, "R6");
        set_cfg(1'b0, 3);
        acc(16'h0000, 2, 1, 0, 8'h00, "R6");
        // R8: mode 11, idle and write-wins
        acc(16'h00A0, 3, 1, 1, 8'hF0, "R8");
        acc(16'h00A0, 3, 1, 0, 8'h00, "R8");
        acc(16'h0020, 0, 0, 0, 8'h00, "R8");
        acc(16'h0020, 0, 1, 1, 8'h4D, "R8");
        acc(16'h0020, 1, 1, 0, 8'h00, "R8");
        acc(16'h0030, 3, 0, 0, 8'h00, "R7");
        // R7 and all routes: random traffic with occasional reconfiguration
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 19));
            if (sel == 0) set_cfg(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
            else if (sel < 8)
                acc(16'($urandom_range(0, 16'h0900)), 2, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    8'($urandom), "R7");
            else
                acc(16'($urandom_range(0, 255)), int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 8'($urandom), "R7");
        end
        acc(16'h0000, 3, 0, 0, 8'h00, "R7");
        @(negedge clk);
        chk(rd_data === exp_rd, prev_tag, "rd_data", int'(rd_data), int'(exp_rd));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule